// File: doc/BRIEF.md
# Predicated Mixed-Sign Saturating Vector Adder

This block adds two vectors lane by lane. In each lane the first operand is read as a two's-complement signed integer and the second as an unsigned integer. The exact sum is clamped to the signed range of the lane. A 2-bit size code, sampled with each strobe, picks the lane width, so one datapath serves byte, halfword, word and doubleword elements.

A predicate mask with one bit per byte picks the lanes that are written. A lane whose governing bit is clear passes its first-operand element through untouched. The output therefore stands for the first operand register after an in-place update. A per-lane flag marks each active lane whose sum was clamped.

The block has no handshake. A single-cycle input strobe launches one operation. The result, the flags and an output-valid pulse appear one clock later and then hold until the next strobe.

Top module: `mixsat_vadd`

## Requirements
- R1: The size code sets the lane width N as 8 shifted left by the code: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 64. The vector holds VLEN/N lanes, and lane e occupies bits [e*N +: N] of each operand and of the result.
- R2: In an active lane the first operand is taken as signed and the second as unsigned. While the exact sum is no greater than 2^(N-1)-1, the lane result is that exact sum. This covers negative sums, such as the most negative value plus zero.
- R3: When the exact sum of an active lane exceeds 2^(N-1)-1, the lane result is 2^(N-1)-1. An example in 8-bit lanes is 0x7F plus 0xFF, which gives 0x7F.
- R4: Lane e is governed only by predicate bit e*(N/8). The other predicate bits in that lane's byte group have no effect on the result or on the flags.
- R5: A lane whose governing predicate bit is 0 outputs its first-operand element unchanged and raises no saturation flag.
- R6: Saturation flag bit e*(N/8) is 1 exactly when lane e is active and was clamped. Every other flag bit is 0.
- R7: The output-valid signal is high in the cycle after a strobe and low otherwise. The result and the flags update on the same edge and keep their values while no strobe is given.
- R8: A synchronous active-high reset clears the output-valid signal, the result and the flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Strobe that launches one operation |
| opa | input | VLEN | Signed first operand, also the pass-through value |
| opb | input | VLEN | Unsigned second operand |
| pred | input | VLEN/8 | Predicate mask, one bit per byte |
| size | input | 2 | Lane width code |
| out_vld | output | 1 | High one cycle after a strobe |
| res | output | VLEN | Registered result vector |
| sat | output | VLEN/8 | Registered saturation flags at lane-start byte positions |

## Verification
The result vector, the flags and the valid pulse all come from one register stage, so each one is due on the first rising edge after the strobe is seen. The driver sets inputs on the falling edge and queues the expected result computed in full precision. The monitor samples on the next falling edge, a half cycle after the capturing edge, and pops only when output-valid is high. On falling edges with valid low it checks that the result and the flags held their last values.

// File: rtl/mixsat_pkg.sv
package mixsat_pkg;
  typedef enum logic [1:0] {
    LW_8  = 2'b00,
    LW_16 = 2'b01,
    LW_32 = 2'b10,
    LW_64 = 2'b11
  } lane_w_e;

  localparam int NUM_WIDTHS = 4;
  localparam int MAX_LANE_W = 64;
endpackage

// File: rtl/mixsat_lane.sv
module mixsat_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         en,
  output logic [W-1:0] r,
  output logic         clamp
);
  localparam int SW = W + 2;

  logic [SW-1:0] sum;
  logic          over;

  // a is sign extended and b is zero extended; W+2 bits hold every exact sum
  assign sum  = {{2{a[W-1]}}, a} + {2'b00, b};
  // A non-negative sum with any bit at or above W-1 lies beyond the positive limit
  assign over = ~sum[SW-1] & (sum[W] | sum[W-1]);

  always_comb begin
    if (!en)       r = a;
    else if (over) r = {1'b0, {(W-1){1'b1}}};
    else           r = sum[W-1:0];
  end

  assign clamp = en & over;
endmodule

// File: rtl/mixsat_bank.sv
module mixsat_bank #(
  parameter int VLEN = 128,
  parameter int W    = 8
) (
  input  logic [VLEN-1:0]   opa,
  input  logic [VLEN-1:0]   opb,
  input  logic [VLEN/W-1:0] lane_en,
  output logic [VLEN-1:0]   res,
  output logic [VLEN/W-1:0] lane_sat
);
  localparam int LANES = VLEN / W;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    mixsat_lane #(.W(W)) u_lane (
      .a    (opa[e*W +: W]),
      .b    (opb[e*W +: W]),
      .en   (lane_en[e]),
      .r    (res[e*W +: W]),
      .clamp(lane_sat[e])
    );
  end
endmodule

// File: rtl/mixsat_vadd.sv
module mixsat_vadd
  import mixsat_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [VLEN-1:0]   opa,
  input  logic [VLEN-1:0]   opb,
  input  logic [VLEN/8-1:0] pred,
  input  logic [1:0]        size,
  output logic              out_vld,
  output logic [VLEN-1:0]   res,
  output logic [VLEN/8-1:0] sat
);
  localparam int NB = VLEN / 8;

  logic [VLEN-1:0] bank_res [NUM_WIDTHS];
  logic [NB-1:0]   bank_sat [NUM_WIDTHS];

  for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
    localparam int W     = 8 << k;
    localparam int STEP  = W / 8;
    localparam int LANES = VLEN / W;

    logic [LANES-1:0] en_k;
    logic [LANES-1:0] sat_k;

    for (genvar e = 0; e < LANES; e++) begin : g_map
      assign en_k[e]               = pred[e*STEP];
      assign bank_sat[k][e*STEP]   = sat_k[e];
      if (STEP > 1) begin : g_pad
        assign bank_sat[k][e*STEP+1 +: STEP-1] = '0;
      end
    end

    mixsat_bank #(.VLEN(VLEN), .W(W)) u_bank (
      .opa     (opa),
      .opb     (opb),
      .lane_en (en_k),
      .res     (bank_res[k]),
      .lane_sat(sat_k)
    );
  end

  logic [VLEN-1:0] sel_res;
  logic [NB-1:0]   sel_sat;

  always_comb begin
    case (lane_w_e'(size))
      LW_8:    begin sel_res = bank_res[0]; sel_sat = bank_sat[0]; end
      LW_16:   begin sel_res = bank_res[1]; sel_sat = bank_sat[1]; end
      LW_32:   begin sel_res = bank_res[2]; sel_sat = bank_sat[2]; end
      default: begin sel_res = bank_res[3]; sel_sat = bank_sat[3]; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      res     <= '0;
      sat     <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        res <= sel_res;
        sat <= sel_sat;
      end
    end
  end
endmodule

// File: rtl/mixsat_vadd_chk.sv
module mixsat_vadd_chk #(
  parameter int VLEN = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [VLEN-1:0]   opa,
  input logic [VLEN/8-1:0] pred,
  input logic [1:0]        size,
  input logic              out_vld,
  input logic [VLEN-1:0]   res,
  input logic [VLEN/8-1:0] sat
);
  localparam int NB = VLEN / 8;

  function automatic logic [NB-1:0] start_mask(input logic [1:0] sz);
    logic [NB-1:0] m;
    int step;
    step = 1 << sz;
    m = '0;
    for (int i = 0; i < NB; i++) if (i % step == 0) m[i] = 1'b1;
    return m;
  endfunction

  assert_valid_R7: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!out_vld && $stable(res) && $stable(sat)));

  assert_flag_active_R6: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ((sat & ~$past(pred)) == '0 && (sat & ~start_mask($past(size))) == '0));

  assert_passthru_R5: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(pred) == '0) |-> (res == $past(opa) && sat == '0));

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assert_clamp_R3: assert property (@(posedge clk) disable iff (rst)
      (out_vld && $past(size) == 2'b00 && sat[i]) |-> res[i*8 +: 8] == 8'h7F);
  end
endmodule

bind mixsat_vadd mixsat_vadd_chk #(.VLEN(VLEN)) u_chk (.*);

// File: tb/mixsat_vadd_bench.sv
module mixsat_vadd_bench;
  localparam int VLEN = 128;
  localparam int NB   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_vld = 1'b0;
  logic [VLEN-1:0] opa = '0, opb = '0;
  logic [NB-1:0]   pred = '0;
  logic [1:0]      size = 2'b00;
  logic            out_vld;
  logic [VLEN-1:0] res;
  logic [NB-1:0]   sat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [VLEN-1:0] q_res [$];
  logic [NB-1:0]   q_sat [$];
  string           q_tag [$];

  always #10 clk = ~clk;

  mixsat_vadd #(.VLEN(VLEN)) u_mixsat_vadd (
    .clk(clk), .rst(rst), .in_vld(in_vld), .opa(opa), .opb(opb),
    .pred(pred), .size(size), .out_vld(out_vld), .res(res), .sat(sat)
  );

  task automatic check_vec(input string tag, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Full-precision model of the lane rules
  task automatic ref_calc(input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                          input logic [NB-1:0] p, input logic [1:0] sz,
                          output logic [VLEN-1:0] r, output logic [NB-1:0] s);
    int n, lanes;
    logic signed [67:0] two_n, mx, sa, ub, sum, rv;
    logic [63:0] ae, be;
    n = 8 << sz;
    lanes = VLEN / n;
    r = '0;
    s = '0;
    two_n = 68'sd1 <<< n;
    mx = (two_n >>> 1) - 68'sd1;
    for (int e = 0; e < lanes; e++) begin
      ae = '0;
      be = '0;
      for (int j = 0; j < n; j++) begin
        ae[j] = a[e*n + j];
        be[j] = b[e*n + j];
      end
      sa = $signed({4'b0000, ae});
      if (ae[n-1]) sa = sa - two_n;
      ub = $signed({4'b0000, be});
      sum = sa + ub;
      if (!p[e*(n/8)]) rv = $signed({4'b0000, ae});
      else if (sum > mx) begin
        rv = mx;
        s[e*(n/8)] = 1'b1;
      end else rv = sum;
      for (int j = 0; j < n; j++) r[e*n + j] = rv[j];
    end
  endtask

  function automatic logic [VLEN-1:0] fill(input logic [63:0] v, input logic [1:0] sz);
    logic [VLEN-1:0] f;
    int n;
    n = 8 << sz;
    f = '0;
    for (int i = 0; i < VLEN; i++) f[i] = v[i % n];
    return f;
  endfunction

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int w = 0; w < VLEN/32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic drive(input string tag, input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                       input logic [NB-1:0] p, input logic [1:0] sz);
    logic [VLEN-1:0] er;
    logic [NB-1:0]   es;
    @(negedge clk);
    opa = a; opb = b; pred = p; size = sz; in_vld = 1'b1;
    ref_calc(a, b, p, sz, er, es);
    q_res.push_back(er);
    q_sat.push_back(es);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      opa = rnd_vec(); opb = rnd_vec(); pred = '1;
    end
  endtask

  // Monitor: results are due one rising edge after the strobe; sampled on the falling edge
  logic [VLEN-1:0] last_res;
  logic [NB-1:0]   last_sat;
  bit              have_last = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_vld) begin
        if (q_res.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7: out_vld high with nothing expected, got 1 expected 0");
        end else begin
          string t;
          logic [VLEN-1:0] er;
          logic [NB-1:0] es;
          t = q_tag.pop_front();
          er = q_res.pop_front();
          es = q_sat.pop_front();
          check_vec(t, res, er);
          checks++;
          if (sat !== es) begin
            errors++;
            $display("FAIL R6 (%s) flags: got %h expected %h", t, sat, es);
          end
        end
        last_res = res; last_sat = sat; have_last = 1;
      end else if (!rst && have_last) begin
        check_vec("R7 hold res", res, last_res);
        checks++;
        if (sat !== last_sat) begin
          errors++;
          $display("FAIL R7 hold flags: got %h expected %h", sat, last_sat);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] mn, mxp;
    repeat (3) @(negedge clk);
    // R8: reset state
    checks++;
    if (out_vld !== 1'b0 || res !== '0 || sat !== '0) begin
      errors++;
      $display("FAIL R8: got vld=%b res=%h sat=%h expected 0 0 0", out_vld, res, sat);
    end
    @(negedge clk);
    rst = 1'b0;

    for (int s = 0; s < 4; s++) begin
      logic [1:0] sz;
      logic [NB-1:0] odd;
      sz = 2'(s);
      mxp = 64'h7FFF_FFFF_FFFF_FFFF >> (64 - (8 << s));
      mn  = mxp + 64'd1;
      // R1: unsigned all-ones lanes on zero give width-specific clamps
      drive("R1", '0, '1, '1, sz);
      // R2: most negative value plus zero stays put
      drive("R2 min+0", fill(mn, sz), '0, '1, sz);
      // R2: most negative plus all-ones gives the positive limit minus... exact -1+2^(N-1)
      drive("R2 min+max", fill(mn, sz), '1, '1, sz);
      // R3: max signed plus max unsigned clamps
      drive("R3", fill(mxp, sz), '1, '1, sz);
      // R5: no lane active, first operand passes
      drive("R5", rnd_vec(), rnd_vec(), '0, sz);
      // R4: only non-governing predicate bits set
      odd = '0;
      for (int i = 0; i < NB; i++) if (i % (1 << s) != 0) odd[i] = 1'b1;
      drive("R4", fill(mxp, sz), '1, odd, sz);
      // R2/R3 mix with random predicate
      for (int i = 0; i < 12; i++) drive("R2 random", rnd_vec(), rnd_vec(), NB'($urandom), sz);
      idle(2);
    end
    // back-to-back with size switching each strobe
    for (int i = 0; i < 16; i++) drive("R1 switch", rnd_vec(), rnd_vec(), NB'($urandom), 2'(i % 4));
    idle(4);

    checks++;
    if (q_res.size() != 0) begin
      errors++;
      $display("FAIL R7: got %0d pending results expected 0", q_res.size());
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule